// File: doc/BRIEF.md
# Decimated Word Readout with Resynchronisation

This block sits between a decimating filter and a host bus. It counts master-clock cycles to mark the end of each output word period (16 or 32 cycles), captures the filter's current result into an output register at that instant, and signals the event on an active-low ready strobe that is low for exactly one cycle. A host reads the captured word by pulling chip-select and read low together. Both are sampled on the master clock, and the bus carries the word plus an enable flag for the pad driver only while both are low.

A resynchronisation input restarts the decimation phase. A pulse counts only if it stays high for a minimum number of cycles. While a counted pulse stays high, the ready strobe is held inactive. When the input drops, a long fixed settling interval passes before the first new word is flagged, and the word cadence then restarts from that point. A change of the decimation ratio is handled the same way, as a restart followed by settling.

Top module: `pr_readout`

## Requirements
- R1: While `rst` is high, `rdy_n` is 1, `dout_en` is 0 and `dout` is 0.
- R2: With `ratio_sel` = 0 the word period is BASE_RATIO (16) cycles, and with `ratio_sel` = 1 it is 2*BASE_RATIO (32). The first strobe after reset release comes on the period-th rising edge, and each later strobe follows one period after the previous one.
- R3: `rdy_n` goes low for exactly one cycle per word and is high at all other times.
- R4: `dout_en` and `dout` follow the `cs_n`/`rd_n` sample taken at each rising edge. If either was high, `dout_en` is 0 and `dout` is 0.
- R5: A `sync_in` pulse that is high for fewer than SYNC_MIN (4) sampled edges is ignored, and the word cadence carries on unchanged.
- R6: Once `sync_in` has been high for more than SYNC_MIN sampled edges, `rdy_n` stays high for as long as it stays high.
- R7: After a recognised sync, the first new strobe is produced SETTLE_CYC+1 (2050) rising edges after the edge that first samples `sync_in` low. Strobes then follow at the normal period.
- R8: `rdy_n` falls on the same edge that loads `res_in` into the output word. A read first sampled after that edge returns the new word.
- R9: While a read stays asserted, `dout` keeps the word it returned first, even if new words arrive. A read asserted again after release returns the latest word.
- R10: A change of `ratio_sel` restarts the cadence like a sync. No strobe comes on the second edge after the change is sampled. The first strobe at the new ratio arrives SETTLE_CYC+1 edges after the edge that samples the change, and later strobes come at the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 1 | Decimation ratio: 0 = BASE_RATIO, 1 = 2*BASE_RATIO |
| sync_in | input | 1 | Resynchronisation request, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read, active low |
| res_in | input | DATA_W | Current filter result |
| rdy_n | output | 1 | Word-ready strobe, active low, one cycle |
| dout | output | DATA_W | Read data, 0 when not reading |
| dout_en | output | 1 | Bus drive enable for the read data |

## Verification
The cadence is measured with both ratio settings, from reset release and after each restart. This separates an off-by-one in the period counter from one in the settling counter. Sync pulses are applied both one cycle short of and well beyond the qualification width, which shows whether the qualifier's threshold is placed correctly. Reads are issued just after a strobe, across a strobe while held, and with only one of the two select lines low. These cases distinguish the timing of the output-register update, the hold-while-reading rule and the AND-gating of the two lines.

// File: rtl/pr_pkg.sv
package pr_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HOLD   = 2'd1,
    ST_SETTLE = 2'd2
  } phase_t;
endpackage

// File: rtl/pr_sync_qual.sv
module pr_sync_qual #(
  parameter int SYNC_MIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic sync_lvl,
  output logic sync_hit
);
  localparam int HC_W = (SYNC_MIN < 2) ? 1 : $clog2(SYNC_MIN + 1);
  localparam logic [HC_W-1:0] HC_TOP = HC_W'(SYNC_MIN - 1);

  logic [HC_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_lvl <= 1'b0;
      hi_cnt   <= '0;
    end else begin
      sync_lvl <= sync_in;
      if (!sync_lvl)
        hi_cnt <= '0;
      else if (hi_cnt != HC_TOP)
        hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign sync_hit = sync_lvl && (hi_cnt == HC_TOP);
endmodule

// File: rtl/pr_word_timer.sv
module pr_word_timer
  import pr_pkg::*;
#(
  parameter int BASE_RATIO = 16,
  parameter int SETTLE_CYC = 2049
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_hit,
  input  logic sync_lvl,
  input  logic ratio_chg,
  input  logic long_ratio,
  output logic strobe
);
  localparam int CNT_W = $clog2(2 * BASE_RATIO);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(BASE_RATIO - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(2 * BASE_RATIO - 1);
  localparam logic [SET_W-1:0] SET_END    = SET_W'(SETTLE_CYC);

  phase_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [SET_W-1:0]  scnt;
  logic [CNT_W-1:0]  last;
  logic              run_end;
  logic              set_end;

  assign last    = long_ratio ? LAST_LONG : LAST_SHORT;
  assign run_end = (st == ST_RUN) && (cnt == last);
  assign set_end = (st == ST_SETTLE) && (scnt == SET_END);
  assign strobe  = !sync_hit && !ratio_chg && (run_end || set_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_RUN;
      cnt  <= '0;
      scnt <= '0;
    end else if (sync_hit) begin
      st  <= ST_HOLD;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_HOLD: begin
          if (!sync_lvl) begin
            st   <= ST_SETTLE;
            scnt <= SET_W'(1);
          end
        end
        ST_SETTLE: begin
          if (ratio_chg)
            scnt <= SET_W'(1);
          else if (set_end) begin
            st  <= ST_RUN;
            cnt <= '0;
          end else
            scnt <= scnt + 1'b1;
        end
        default: begin
          if (ratio_chg) begin
            st   <= ST_SETTLE;
            scnt <= SET_W'(1);
            cnt  <= '0;
          end else if (run_end)
            cnt <= '0;
          else
            cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pr_read_port.sv
module pr_read_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] res_in,
  input  logic              cs_n,
  input  logic              rd_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic [DATA_W-1:0] word_q;
  logic              rd_req;

  assign rd_req = !cs_n && !rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      if (strobe)
        word_q <= res_in;
      dout_en <= rd_req;
      if (!rd_req)
        dout <= '0;
      else if (!dout_en)
        dout <= word_q;
    end
  end
endmodule

// File: rtl/pr_readout.sv
module pr_readout #(
  parameter int DATA_W     = 16,
  parameter int BASE_RATIO = 16,
  parameter int SYNC_MIN   = 4,
  parameter int SETTLE_CYC = 2049
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ratio_sel,
  input  logic              sync_in,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] res_in,
  output logic              rdy_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic sync_lvl;
  logic sync_hit;
  logic ratio_r;
  logic ratio_q;
  logic strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_r <= ratio_sel;
      ratio_q <= ratio_sel;
      rdy_n   <= 1'b1;
    end else begin
      ratio_r <= ratio_sel;
      ratio_q <= ratio_r;
      rdy_n   <= !strobe;
    end
  end

  pr_sync_qual #(.SYNC_MIN(SYNC_MIN)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sync_in  (sync_in),
    .sync_lvl (sync_lvl),
    .sync_hit (sync_hit)
  );

  pr_word_timer #(.BASE_RATIO(BASE_RATIO), .SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .sync_hit   (sync_hit),
    .sync_lvl   (sync_lvl),
    .ratio_chg  (ratio_r != ratio_q),
    .long_ratio (ratio_q),
    .strobe     (strobe)
  );

  pr_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .res_in  (res_in),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .dout    (dout),
    .dout_en (dout_en)
  );
endmodule

// File: rtl/pr_readout_chk.sv
module pr_readout_chk #(
  parameter int DATA_W   = 16,
  parameter int SYNC_MIN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ratio_sel,
  input logic              sync_in,
  input logic              cs_n,
  input logic              rd_n,
  input logic              rdy_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  localparam int HR_W = $clog2(SYNC_MIN + 2);
  localparam logic [HR_W-1:0] HR_TOP = HR_W'(SYNC_MIN + 1);

  logic [HR_W-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst)
      hi_run <= '0;
    else if (!sync_in)
      hi_run <= '0;
    else if (hi_run != HR_TOP)
      hi_run <= hi_run + 1'b1;
  end

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (rst)
    !rdy_n |=> rdy_n);

  p_sync_blank_r6: assert property (@(posedge clk) disable iff (rst)
    (hi_run == HR_TOP) |-> rdy_n);

  p_read_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |=> (!dout_en && dout == '0));

  p_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && dout_en) |=> (dout_en && $stable(dout)));

  p_ratio_blank_r10: assert property (@(posedge clk) disable iff (rst)
    (ratio_sel != $past(ratio_sel)) |-> ##2 rdy_n);
endmodule

bind pr_readout pr_readout_chk #(.DATA_W(DATA_W), .SYNC_MIN(SYNC_MIN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ratio_sel (ratio_sel),
  .sync_in   (sync_in),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .rdy_n     (rdy_n),
  .dout      (dout),
  .dout_en   (dout_en)
);

// File: tb/pr_readout_bench.sv
module pr_readout_bench;
  localparam int TCLK   = 10;
  localparam int DW     = 16;
  localparam int PSHORT = 16;
  localparam int PLONG  = 32;
  localparam int SMIN   = 4;
  localparam int SETTLE = 2049;
  localparam int LIMIT  = 4000;

  logic          clk = 1'b0;
  logic          rst;
  logic          ratio_sel;
  logic          sync_in;
  logic          cs_n;
  logic          rd_n;
  logic [DW-1:0] res_in;
  logic          rdy_n;
  logic [DW-1:0] dout;
  logic          dout_en;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  pr_readout u_pr_readout (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .sync_in(sync_in),
    .cs_n(cs_n), .rd_n(rd_n), .res_in(res_in),
    .rdy_n(rdy_n), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // counts falling edges until rdy_n is seen low; 0 on timeout
  task automatic wait_strobe(output int n);
    n = 0;
    for (int i = 1; i <= LIMIT; i++) begin
      @(negedge clk);
      if (!rdy_n) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic t_reset();
    int n;
    rst = 1'b1; ratio_sel = 1'b0; sync_in = 1'b0;
    cs_n = 1'b1; rd_n = 1'b1; res_in = '0;
    repeat (3) @(negedge clk);
    check(rdy_n == 1'b1 && dout_en == 1'b0 && dout == '0, "R1 reset state",
          {rdy_n, dout_en, dout}, 32'h2_0000);
    rst = 1'b0;
    wait_strobe(n);
    check(n == PSHORT, "R2 first strobe after reset", n, PSHORT);
    @(negedge clk);
    check(rdy_n == 1'b1, "R3 strobe one cycle", rdy_n, 1);
    wait_strobe(n);
    check(n == PSHORT - 1, "R2 short period", n + 1, PSHORT);
  endtask

  task automatic t_read_basic();
    int n;
    res_in = 16'hA5C3;
    wait_strobe(n);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check(dout_en && dout == 16'hA5C3, "R8 read after strobe sees new word", dout, 16'hA5C3);
    rd_n = 1'b1;
    @(negedge clk);
    check(!dout_en && dout == '0, "R4 cs only low", {dout_en, dout}, 0);
    cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    check(!dout_en && dout == '0, "R4 rd only low", {dout_en, dout}, 0);
    rd_n = 1'b1;
  endtask

  task automatic t_read_hold();
    int n;
    res_in = 16'h1111;
    wait_strobe(n);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check(dout == 16'h1111, "R9 first word", dout, 16'h1111);
    res_in = 16'h2222;
    wait_strobe(n);
    check(dout_en && dout == 16'h1111, "R9 word held across strobe", dout, 16'h1111);
    cs_n = 1'b1;
    @(negedge clk);
    check(!dout_en, "R4 release", dout_en, 0);
    cs_n = 1'b0;
    @(negedge clk);
    check(dout_en && dout == 16'h2222, "R9 reread gets latest", dout, 16'h2222);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_short_sync();
    int n;
    wait_strobe(n);
    sync_in = 1'b1;
    repeat (SMIN - 1) @(negedge clk);
    sync_in = 1'b0;
    wait_strobe(n);
    check(n == PSHORT - (SMIN - 1), "R5 short sync ignored", n + SMIN - 1, PSHORT);
  endtask

  task automatic t_sync();
    int n;
    bit all_hi;
    wait_strobe(n);
    sync_in = 1'b1;
    all_hi = 1'b1;
    for (int i = 0; i < 3 * PLONG; i++) begin
      @(negedge clk);
      if (!rdy_n) all_hi = 1'b0;
    end
    check(all_hi, "R6 ready blanked while sync high", all_hi, 1);
    res_in = 16'hBEEF;
    sync_in = 1'b0;
    wait_strobe(n);
    check(n == SETTLE + 2, "R7 settle length", n, SETTLE + 2);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check(dout == 16'hBEEF, "R8 word after settle", dout, 16'hBEEF);
    cs_n = 1'b1; rd_n = 1'b1;
    wait_strobe(n);
    check(n == PSHORT - 1, "R7 cadence after settle", n + 1, PSHORT);
  endtask

  task automatic t_ratio();
    int n;
    wait_strobe(n);
    ratio_sel = 1'b1;
    wait_strobe(n);
    check(n == SETTLE + 2, "R10 ratio change settles", n, SETTLE + 2);
    wait_strobe(n);
    check(n == PLONG, "R10 R2 long period", n, PLONG);
    @(negedge clk);
    check(rdy_n == 1'b1, "R3 strobe one cycle long ratio", rdy_n, 1);
    wait_strobe(n);
    check(n == PLONG - 1, "R2 long period repeat", n + 1, PLONG);
  endtask

  initial begin
    #(TCLK * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_read_basic();
    t_read_hold();
    t_short_sync();
    t_sync();
    t_ratio();
    finish_run();
  end
endmodule